// File: doc/BRIEF.md
# Low Pin Count Bus Peripheral Target

This block is the target side of a Low Pin Count bus for a peripheral. It sits on the 33 MHz bus clock and uses the bus reset as its own reset. It watches the host's active-low frame strobe and the shared 4-bit nibble bus, on which command, address and data follow one another. It claims single-byte I/O reads and writes whose 16-bit address falls inside a window fixed by parameters. It also claims single-byte DMA reads and writes. It answers each claimed cycle with turnaround, ready-sync and data nibbles.

Toward the peripheral it offers a plain register port: an address, write data, read data, and one-clock read and write strobes for I/O. DMA cycles use their own pair of strobes, plus the channel number and terminal-count flag taken from the cycle. Every cycle type it does not claim is ignored, and on those the bus is never driven. When the host pulls the frame strobe low, the output enable drops on the next clock. This lets the host abort a cycle at any point.

Top module: `lpc_target`

## Requirements
- R1: A cycle starts only when the frame strobe is sampled low while the bus carries 0000. The nibble on the following clock is the cycle type. Bits [3:2] = 00 select I/O and 10 select DMA. Bit 1 = 1 means the host sends data (write) and bit 1 = 0 means the target returns data (read). Bit 0 is ignored.
- R2: An I/O address arrives as four nibbles, most significant first. The cycle is claimed only if the address lies in [IO_BASE, IO_BASE+IO_SIZE), which is 0x0060 to 0x006F by default. Outside that window the target drives nothing and pulses no strobe until the next start.
- R3: On an I/O write the two data nibbles arrive low nibble first. On the clock after the high nibble, `regWr` is high for exactly one clock, with `regAddr` and `regWdata` holding the address and byte.
- R4: On an I/O read, `regRd` is high for one clock, on the clock after the last address nibble. `regRdata` is sampled at the end of that clock and returned low nibble first, straight after the sync nibble.
- R5: After the strobe clock, the target waits one further host turnaround clock with the bus released. It then drives the sync value 0000 for one clock. On reads the two data nibbles follow. Last, it drives 1111 for one clock and releases the bus.
- R6: A DMA cycle carries a channel nibble after the type: bits [2:0] are the channel and bit 3 is terminal count. A size nibble follows. Only a size nibble with bits [1:0] = 00 (one byte) is claimed, and any other size is ignored silently. Claimed DMA cycles use `dmaWr`/`dmaRd` with the I/O timing, and present `dmaChan` and `dmaTc`.
- R7: Cycle types with bits [3:2] = 01 or 11 are ignored: no output enable and no strobe.
- R8: Whenever the frame strobe is sampled low, `ladOe` is low on the next clock and a strobe due in that clock is suppressed. If the bus carried 0000 at that edge, a new cycle begins.
- R9: While reset is asserted, `ladOe` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz bus clock |
| rstN | input | 1 | Bus reset, active low, asynchronous |
| frameN | input | 1 | Host frame strobe, active low |
| ladIn | input | 4 | Nibble bus as seen at the pins |
| ladOut | output | 4 | Nibble the target drives |
| ladOe | output | 1 | Output enable for the nibble bus |
| regAddr | output | 16 | I/O address of the current cycle |
| regWdata | output | 8 | Byte received from the host |
| regRdata | input | 8 | Byte the peripheral returns |
| regWr | output | 1 | One-clock I/O write strobe |
| regRd | output | 1 | One-clock I/O read strobe |
| dmaChan | output | 3 | DMA channel of the current cycle |
| dmaTc | output | 1 | DMA terminal-count flag |
| dmaWr | output | 1 | One-clock DMA write strobe |
| dmaRd | output | 1 | One-clock DMA read strobe |

## Verification
The bench probes the window edges at 0x005F, 0x0060, 0x006F and 0x0070. A comparator off by one would claim or drop a neighbouring port. It aborts a read while the sync nibble is on the bus, and aborts a write in its data phase by starting a new cycle at once. A target that ignored the strobe would keep driving against the host, or would fire a stale write. DMA cycles with wider size codes and memory-type commands must stay silent; a decoder that looked at too few bits would answer them. Random mixes of every type nibble, sizes and near-window addresses then check strobe choice, nibble order and turnaround timing against a bench model.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  localparam int IDX_W = 2;

  localparam logic [3:0] START_NIB = 4'h0;
  localparam logic [3:0] SYNC_NIB  = 4'h0;
  localparam logic [3:0] TAR_NIB   = 4'hF;
  localparam logic [1:0] KIND_IO   = 2'b00;
  localparam logic [1:0] KIND_DMA  = 2'b10;
  localparam logic [1:0] SIZE_BYTE = 2'b00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_DCHAN,
    ST_DSIZE,
    ST_HDATA,
    ST_HTAR,
    ST_SYNC,
    ST_TDATA,
    ST_TTAR
  } tgtState_e;

  typedef enum logic [1:0] {
    DRV_SYNC,
    DRV_DATA,
    DRV_TAR
  } drvSel_e;

  typedef struct packed {
    logic             addrShift;
    logic             dataShift;
    logic             rdCapture;
    logic             chanLoad;
    logic             drvEn;
    drvSel_e          drvSel;
    logic [IDX_W-1:0] nibIdx;
  } dpCtl_t;

endpackage

// File: rtl/lpc_tgt_dp.sv
module lpc_tgt_dp
  import lpc_tgt_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter int unsigned IO_BASE = 'h60,
  parameter int unsigned IO_SIZE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        ladIn,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] regRdata,
  output logic              addrHit,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic [2:0]        dmaChan,
  output logic              dmaTc,
  output logic [3:0]        ladOut,
  output logic              ladOe
);

  localparam int DATA_NIB = DATA_W / 4;
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W + 1)'(IO_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W + 1)'(IO_BASE + IO_SIZE);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] rdReg;
  logic [ADDR_W:0]   addrCand;
  logic [3:0]        drvData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      rdReg   <= '0;
      dmaChan <= '0;
      dmaTc   <= 1'b0;
    end else begin
      if (ctl.addrShift) addrReg <= {addrReg[ADDR_W-5:0], ladIn};
      if (ctl.dataShift) dataReg <= {ladIn, dataReg[DATA_W-1:4]};
      if (ctl.rdCapture) rdReg <= regRdata;
      if (ctl.chanLoad) begin
        dmaChan <= ladIn[2:0];
        dmaTc   <= ladIn[3];
      end
    end
  end

  // Window test on the address as it will stand after this nibble
  always_comb begin
    addrCand = {1'b0, addrReg[ADDR_W-5:0], ladIn};
    addrHit  = (addrCand >= WIN_LO) && (addrCand < WIN_HI);
  end

  always_comb begin
    drvData = '0;
    for (int i = 0; i < DATA_NIB; i++) begin
      if (ctl.nibIdx == IDX_W'(i)) drvData = rdReg[i*4 +: 4];
    end
  end

  always_comb begin
    unique case (ctl.drvSel)
      DRV_DATA: ladOut = drvData;
      DRV_TAR:  ladOut = TAR_NIB;
      default:  ladOut = SYNC_NIB;
    endcase
    ladOe = ctl.drvEn;
  end

  assign regAddr  = addrReg;
  assign regWdata = dataReg;

endmodule

// File: rtl/lpc_tgt_ctrl.sv
module lpc_tgt_ctrl
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic [3:0] ladIn,
  input  logic       addrHit,
  output dpCtl_t     ctl,
  output logic       regWr,
  output logic       regRd,
  output logic       dmaWr,
  output logic       dmaRd
);

  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int DATA_NIB = DATA_W / 4;
  localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_NIB - 1);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_NIB - 1);
  localparam logic [IDX_W-1:0] TAR_LAST  = IDX_W'(1);

  tgtState_e        state, stateNxt;
  logic [IDX_W-1:0] cnt, cntNxt;
  logic             isDma, isWrite;
  logic             strobeSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isDma   <= 1'b0;
      isWrite <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      if (state == ST_CTYPE && frameN) begin
        isDma   <= (ladIn[3:2] == KIND_DMA);
        isWrite <= ladIn[1];
      end
    end
  end

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    ctl      = '0;
    unique case (state)
      ST_IDLE: ;
      ST_CTYPE: begin
        cntNxt = '0;
        if (ladIn[3:2] == KIND_IO)       stateNxt = ST_ADDR;
        else if (ladIn[3:2] == KIND_DMA) stateNxt = ST_DCHAN;
        else                             stateNxt = ST_IDLE;
      end
      ST_ADDR: begin
        ctl.addrShift = 1'b1;
        if (cnt == ADDR_LAST) begin
          cntNxt   = '0;
          stateNxt = !addrHit ? ST_IDLE : (isWrite ? ST_HDATA : ST_HTAR);
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_DCHAN: begin
        ctl.chanLoad = 1'b1;
        stateNxt     = ST_DSIZE;
      end
      ST_DSIZE: begin
        cntNxt   = '0;
        stateNxt = (ladIn[1:0] != SIZE_BYTE) ? ST_IDLE :
                   (isWrite ? ST_HDATA : ST_HTAR);
      end
      ST_HDATA: begin
        ctl.dataShift = 1'b1;
        if (cnt == DATA_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_HTAR;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_HTAR: begin
        ctl.rdCapture = (cnt == '0) && !isWrite;
        if (cnt == TAR_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_SYNC;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_SYNC: begin
        ctl.drvEn  = 1'b1;
        ctl.drvSel = DRV_SYNC;
        cntNxt     = '0;
        stateNxt   = isWrite ? ST_TTAR : ST_TDATA;
      end
      ST_TDATA: begin
        ctl.drvEn  = 1'b1;
        ctl.drvSel = DRV_DATA;
        ctl.nibIdx = cnt;
        if (cnt == DATA_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_TTAR;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_TTAR: begin
        ctl.drvEn  = 1'b1;
        ctl.drvSel = DRV_TAR;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
    // A low frame strobe overrides everything: restart or go quiet
    if (!frameN) begin
      cntNxt   = '0;
      stateNxt = (ladIn == START_NIB) ? ST_CTYPE : ST_IDLE;
    end
  end

  always_comb begin
    strobeSlot = (state == ST_HTAR) && (cnt == '0) && frameN;
    regWr = strobeSlot && !isDma && isWrite;
    regRd = strobeSlot && !isDma && !isWrite;
    dmaWr = strobeSlot && isDma && isWrite;
    dmaRd = strobeSlot && isDma && !isWrite;
  end

endmodule

// File: rtl/lpc_target.sv
module lpc_target
  import lpc_tgt_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter int unsigned IO_BASE = 'h60,
  parameter int unsigned IO_SIZE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [3:0]        ladIn,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic              regWr,
  output logic              regRd,
  output logic [2:0]        dmaChan,
  output logic              dmaTc,
  output logic              dmaWr,
  output logic              dmaRd
);

  dpCtl_t ctl;
  logic   addrHit;

  lpc_tgt_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .frameN (frameN),
    .ladIn  (ladIn),
    .addrHit(addrHit),
    .ctl    (ctl),
    .regWr  (regWr),
    .regRd  (regRd),
    .dmaWr  (dmaWr),
    .dmaRd  (dmaRd)
  );

  lpc_tgt_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IO_BASE(IO_BASE),
    .IO_SIZE(IO_SIZE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ladIn   (ladIn),
    .ctl     (ctl),
    .regRdata(regRdata),
    .addrHit (addrHit),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .dmaChan (dmaChan),
    .dmaTc   (dmaTc),
    .ladOut  (ladOut),
    .ladOe   (ladOe)
  );

endmodule

// File: rtl/lpc_target_chk.sv
module lpc_target_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameN,
  input logic       ladOe,
  input logic [3:0] ladOut,
  input logic       regWr,
  input logic       regRd,
  input logic       dmaWr,
  input logic       dmaRd
);

  logic anyStrobe;
  assign anyStrobe = regWr | regRd | dmaWr | dmaRd;

  // R8: bus released on the clock after a low frame strobe
  p_release_on_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> !ladOe);

  // R6: at most one strobe at a time
  p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWr, regRd, dmaWr, dmaRd}));

  // R3: strobes last a single clock
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> !anyStrobe);

  // R5: second turnaround clock leaves the bus released
  p_tar_released_r5: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> !ladOe);

  // R5: the first driven nibble is the ready sync
  p_sync_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ladOe) |-> (ladOut == 4'h0));

  // R9: quiet outputs while in reset
  always @(negedge clk) begin
    if (!rstN) begin
      a_reset_quiet_r9: assert (!ladOe && !anyStrobe);
    end
  end

endmodule

bind lpc_target lpc_target_chk u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .frameN(frameN),
  .ladOe (ladOe),
  .ladOut(ladOut),
  .regWr (regWr),
  .regRd (regRd),
  .dmaWr (dmaWr),
  .dmaRd (dmaRd)
);

// File: tb/lpc_target_test.sv
`timescale 1ns/1ps
module lpc_target_test;

  localparam int unsigned BASE = 'h60;
  localparam int unsigned SIZE = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic [3:0]  ladIn = 4'hF;
  logic [3:0]  ladOut;
  logic        ladOe;
  logic [15:0] regAddr;
  logic [7:0]  regWdata;
  logic [7:0]  rdVal = 8'h00;
  logic        regWr, regRd, dmaWr, dmaRd;
  logic [2:0]  dmaChan;
  logic        dmaTc;

  int checks = 0;
  int errors = 0;
  bit sawOe, sawStrobe;

  always #2 clk = ~clk;

  lpc_target #(.IO_BASE(BASE), .IO_SIZE(SIZE)) uut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .ladIn(ladIn),
    .ladOut(ladOut), .ladOe(ladOe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(rdVal), .regWr(regWr), .regRd(regRd), .dmaChan(dmaChan),
    .dmaTc(dmaTc), .dmaWr(dmaWr), .dmaRd(dmaRd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, observe at the next falling edge
  task automatic clk1(input logic fr, input logic [3:0] nib);
    frameN = fr;
    ladIn  = nib;
    @(posedge clk);
    @(negedge clk);
    sawOe     |= ladOe;
    sawStrobe |= (regWr | regRd | dmaWr | dmaRd);
  endtask

  function automatic bit inWin(input logic [15:0] a);
    return (32'(a) >= BASE) && (32'(a) < BASE + SIZE);
  endfunction

  function automatic bit claimed(input logic [3:0] ct, input logic [15:0] a,
                                 input logic [3:0] sz);
    if (ct[3:2] == 2'b00) return inWin(a);
    if (ct[3:2] == 2'b10) return sz[1:0] == 2'b00;
    return 1'b0;
  endfunction

  // expected {regWr, regRd, dmaWr, dmaRd}
  function automatic logic [3:0] expStrobes(input logic [3:0] ct);
    case ({ct[3:2], ct[1]})
      3'b001:  return 4'b1000;
      3'b000:  return 4'b0100;
      3'b101:  return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic runCycle(input logic [3:0] ct, input logic [15:0] a,
                          input logic [3:0] chNib, input logic [3:0] sz,
                          input logic [7:0] wd, input logic [7:0] rv,
                          input string tag);
    bit acc;
    bit wr;
    logic [3:0] st;
    acc = claimed(ct, a, sz);
    wr  = ct[1];
    rdVal = rv;
    sawOe = 0;
    sawStrobe = 0;
    clk1(1'b0, 4'h0);
    clk1(1'b1, ct);
    if (ct[3:2] == 2'b00) begin
      for (int i = 3; i >= 0; i--) clk1(1'b1, a[i*4 +: 4]);
    end else if (ct[3:2] == 2'b10) begin
      clk1(1'b1, chNib);
      clk1(1'b1, sz);
    end
    if (!acc) begin
      for (int i = 0; i < 12; i++) clk1(1'b1, 4'($urandom));
      chk(!sawOe && !sawStrobe, {tag, " R2/R6/R7 ignored cycle stays silent"},
          {sawOe, sawStrobe}, 0);
      return;
    end
    if (wr) begin
      clk1(1'b1, wd[3:0]);
      clk1(1'b1, wd[7:4]);
    end
    st = {regWr, regRd, dmaWr, dmaRd};
    chk(st == expStrobes(ct) && !ladOe, {tag, " R3/R4/R6 strobe choice"}, st,
        expStrobes(ct));
    if (ct[3:2] == 2'b00)
      chk(regAddr == a && (!wr || regWdata == wd), {tag, " R2/R3 address and data"},
          {regAddr, regWdata}, {a, wr ? wd : regWdata});
    else
      chk(dmaChan == chNib[2:0] && dmaTc == chNib[3] && (!wr || regWdata == wd),
          {tag, " R6 channel, tc and data"}, {dmaTc, dmaChan, regWdata},
          {chNib[3], chNib[2:0], wr ? wd : regWdata});
    clk1(1'b1, 4'hF);
    chk(!ladOe, {tag, " R5 second turnaround released"}, ladOe, 0);
    clk1(1'b1, 4'hF);
    chk(ladOe && ladOut == 4'h0, {tag, " R5 sync nibble"}, {ladOe, ladOut}, 5'h10);
    if (!wr) begin
      clk1(1'b1, 4'hF);
      chk(ladOe && ladOut == rv[3:0], {tag, " R4 low data nibble"}, ladOut, rv[3:0]);
      clk1(1'b1, 4'hF);
      chk(ladOe && ladOut == rv[7:4], {tag, " R4 high data nibble"}, ladOut, rv[7:4]);
    end
    clk1(1'b1, 4'hF);
    chk(ladOe && ladOut == 4'hF, {tag, " R5 closing turnaround"}, {ladOe, ladOut}, 5'h1F);
    clk1(1'b1, 4'hF);
    chk(!ladOe, {tag, " R5 bus released at end"}, ladOe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] ct, sz, chNib;
    logic [15:0] a;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(!ladOe && !(regWr | regRd | dmaWr | dmaRd), "R9 quiet in reset", ladOe, 0);
    rstN = 1'b1;
    @(negedge clk);

    // window edges and directed types
    runCycle(4'b0010, 16'h0060, 4'h0, 4'h0, 8'h3C, 8'h00, "io wr low edge");
    runCycle(4'b0010, 16'h005F, 4'h0, 4'h0, 8'h11, 8'h00, "io wr below window");
    runCycle(4'b0000, 16'h006F, 4'h0, 4'h0, 8'h00, 8'hA7, "io rd high edge");
    runCycle(4'b0001, 16'h0070, 4'h0, 4'h0, 8'h00, 8'h5A, "io rd above window");
    runCycle(4'b1011, 16'h0000, 4'hD, 4'h0, 8'hE1, 8'h00, "dma wr ch5 tc");
    runCycle(4'b1000, 16'h0000, 4'h2, 4'h4, 8'h00, 8'h96, "dma rd byte");
    runCycle(4'b1010, 16'h0000, 4'h1, 4'h1, 8'h77, 8'h00, "dma wide size R6");
    runCycle(4'b0110, 16'h0060, 4'h0, 4'h0, 8'h00, 8'h00, "memory type R7");
    runCycle(4'b1110, 16'h0060, 4'h0, 4'h0, 8'h00, 8'h00, "reserved type R7");

    // R1: frame low with a non-start nibble must not open a cycle
    sawOe = 0; sawStrobe = 0;
    clk1(1'b0, 4'h5);
    clk1(1'b1, 4'b0010);
    clk1(1'b1, 4'h0); clk1(1'b1, 4'h0); clk1(1'b1, 4'h6); clk1(1'b1, 4'h0);
    for (int i = 0; i < 8; i++) clk1(1'b1, 4'h0);
    chk(!sawOe && !sawStrobe, "R1 no start without 0000", {sawOe, sawStrobe}, 0);

    // R8: abort while the target drives sync
    rdVal = 8'hC3;
    clk1(1'b0, 4'h0); clk1(1'b1, 4'b0000);
    clk1(1'b1, 4'h0); clk1(1'b1, 4'h0); clk1(1'b1, 4'h6); clk1(1'b1, 4'h4);
    clk1(1'b1, 4'hF); clk1(1'b1, 4'hF);
    chk(ladOe && ladOut == 4'h0, "R8 setup: read at sync", {ladOe, ladOut}, 5'h10);
    clk1(1'b0, 4'hF);
    chk(!ladOe, "R8 released after abort", ladOe, 0);
    sawOe = 0; sawStrobe = 0;
    for (int i = 0; i < 6; i++) clk1(1'b1, 4'h0);
    chk(!sawOe && !sawStrobe, "R8 stays quiet after abort", {sawOe, sawStrobe}, 0);

    // R8: abort a write in its data phase by starting a fresh write at once
    sawStrobe = 0;
    clk1(1'b0, 4'h0); clk1(1'b1, 4'b0010);
    clk1(1'b1, 4'h0); clk1(1'b1, 4'h0); clk1(1'b1, 4'h6); clk1(1'b1, 4'h1);
    clk1(1'b1, 4'h9);
    chk(!sawStrobe, "R8 no write before abort", sawStrobe, 0);
    runCycle(4'b0010, 16'h0068, 4'h0, 4'h0, 8'h4B, 8'h00, "R8 restarted write");

    // constrained random mix
    for (int n = 0; n < 160; n++) begin
      ct = 4'($urandom);
      if ($urandom % 4 != 0) ct[3:2] = ($urandom % 2) ? 2'b00 : 2'b10;
      a = ($urandom % 2) ? 16'(16'h005C + ($urandom % 24)) : 16'($urandom);
      chNib = 4'($urandom);
      sz = 4'($urandom);
      if ($urandom % 2) sz[1:0] = 2'b00;
      runCycle(ct, a, chNib, sz, 8'($urandom), 8'($urandom), "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule